// File: doc/BRIEF.md
# Transmit Descriptor Sequencer

This block steps a transmit DMA engine through a ring of descriptors kept in host memory. After a start command it requests a descriptor and inspects the ownership flag returned with it. A descriptor the engine owns has its frame words read one beat at a time and pushed into the transmit FIFO. The sequencer then kicks the MAC, waits for it to report the frame sent, and writes status back to close the descriptor before it moves on to the next one. A descriptor still held by the host parks the sequencer in a suspended state until software issues a poll demand.

Bus mastering and the MAC are outside the block. The fetch, data-read and write-back transfers are each modelled as a request/acknowledge pair, and the end of transmission as a single input. Software sees the current state as a fixed 3-bit code. Three one-cycle event pulses (frame closed, descriptor unavailable, process stopped) feed an interrupt status register elsewhere.

Top module: `txdesc_seq`

## Requirements
- R1: After a synchronous active-high reset, `state_code` is 000 and `desc_req`, `rd_req`, `wb_req`, `fifo_push`, `tx_kick` and all three event outputs are 0.
- R2: In state 000, `cmd_start` (without `cmd_stop`) moves the state to 001 on the next clock. In any other state `cmd_start` has no effect.
- R3: In state 001 `desc_req` is 1. On `desc_ack` with `desc_own`=1 the state becomes 011 if `desc_len` is non-zero, and 010 (with no data read) if `desc_len` is 0.
- R4: On `desc_ack` with `desc_own`=0 in state 001, the state becomes 110 and `ev_tx_unavail` is 1 for exactly that one cycle.
- R5: In state 110, `poll_demand` returns the state to 001 on the next clock. In states 000 and 001, `poll_demand` has no effect.
- R6: In state 011, `rd_req` is 1 exactly when `fifo_full` is 0. A beat is taken only when `rd_ack` and `rd_req` are both 1. Each beat gives `fifo_push`=1 with `fifo_wdata` equal to that beat's `rd_data` one cycle later. After `desc_len` beats the state becomes 010.
- R7: On entry to state 010, `tx_kick` pulses for one cycle. `tx_done` in state 010 moves the state to 111.
- R8: In state 111 `wb_req` is 1. `wb_ack` moves the state to 001 and pulses `ev_tx_int` for one cycle.
- R9: `cmd_stop` in any state other than 000 moves the state to 000 on the next clock and pulses `ev_tx_stopped`. Stop takes priority over any transfer completing in the same cycle, and that transfer raises no event of its own. Stop in state 000 produces no pulse.
- R10: State codes are 000 stopped, 001 fetching descriptor, 011 reading data into the FIFO, 010 waiting for transmission end, 111 closing descriptor, 110 suspended. Codes 100 and 101 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start command |
| cmd_stop | input | 1 | Stop command |
| poll_demand | input | 1 | Software poll demand, resumes from suspend |
| desc_req | output | 1 | Descriptor fetch request |
| desc_ack | input | 1 | Descriptor fetch complete |
| desc_own | input | 1 | Fetched descriptor is owned by the DMA |
| desc_len | input | LEN_W | Frame length in data beats from the descriptor |
| rd_req | output | 1 | Frame data read request |
| rd_ack | input | 1 | One data beat returned |
| rd_data | input | DATA_W | Returned data beat |
| fifo_full | input | 1 | Transmit FIFO cannot accept a word |
| fifo_push | output | 1 | Write strobe to the transmit FIFO |
| fifo_wdata | output | DATA_W | Word written to the transmit FIFO |
| tx_kick | output | 1 | One-cycle pulse telling the MAC to send |
| tx_done | input | 1 | MAC finished sending the frame |
| wb_req | output | 1 | Status write-back request |
| wb_ack | input | 1 | Write-back complete |
| state_code | output | 3 | Current process state code |
| ev_tx_int | output | 1 | Pulse: descriptor closed |
| ev_tx_unavail | output | 1 | Pulse: descriptor unavailable |
| ev_tx_stopped | output | 1 | Pulse: process stopped |

## Verification
The stop command can arrive in the same cycle as the completion of a handshake: a write-back acknowledge in the closing state, a descriptor acknowledge, or a data beat. The bench provokes the closing case by raising `cmd_stop` and `wb_ack` together in state 111. It judges the outcome by `state_code` reading 000, with `ev_tx_stopped` set and `ev_tx_int` clear in the following cycle. The same stop is also checked in the suspended and reading states, where the stopped pulse must appear and no other event may.

// File: rtl/txd_pkg.sv
package txd_pkg;

    // State codes are visible to software; the encoding is fixed.
    typedef enum logic [2:0] {
        TXS_STOP  = 3'b000,
        TXS_FETCH = 3'b001,
        TXS_WAIT  = 3'b010,
        TXS_READ  = 3'b011,
        TXS_SUSP  = 3'b110,
        TXS_CLOSE = 3'b111
    } txs_e;

    typedef struct packed {
        logic done_int;
        logic unavail;
        logic stopped;
        logic kick;
    } txd_evt_t;

    function automatic logic is_active(txs_e s);
        return s != TXS_STOP;
    endfunction

    function automatic logic code_legal(logic [2:0] c);
        return (c != 3'b100) && (c != 3'b101);
    endfunction

endpackage

// File: rtl/txd_fsm.sv
module txd_fsm
    import txd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic poll_demand,
    input  logic desc_ack,
    input  logic desc_own,
    input  logic len_zero,
    input  logic last_beat,
    input  logic tx_done,
    input  logic wb_ack,
    output txs_e state,
    output txs_e nxt
);

    always_comb begin
        nxt = state;
        if (cmd_stop) begin
            nxt = TXS_STOP;
        end else begin
            unique case (state)
                TXS_STOP:  if (cmd_start)   nxt = TXS_FETCH;
                TXS_FETCH: if (desc_ack) begin
                               if (!desc_own)    nxt = TXS_SUSP;
                               else if (len_zero) nxt = TXS_WAIT;
                               else               nxt = TXS_READ;
                           end
                TXS_READ:  if (last_beat)   nxt = TXS_WAIT;
                TXS_WAIT:  if (tx_done)     nxt = TXS_CLOSE;
                TXS_CLOSE: if (wb_ack)      nxt = TXS_FETCH;
                TXS_SUSP:  if (poll_demand) nxt = TXS_FETCH;
                default:                    nxt = TXS_STOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TXS_STOP;
        else     state <= nxt;
    end

    AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (rst)
        code_legal(state)); // R10

    AST_START_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state == TXS_STOP && cmd_start && !cmd_stop) |=> (state == TXS_FETCH)); // R2

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |=> (state == TXS_STOP)); // R9

    AST_NOT_OWN_SUSPENDS: assert property (@(posedge clk) disable iff (rst)
        (state == TXS_FETCH && desc_ack && !desc_own && !cmd_stop) |=> (state == TXS_SUSP)); // R4

    AST_POLL_RESUMES: assert property (@(posedge clk) disable iff (rst)
        (state == TXS_SUSP && poll_demand && !cmd_stop) |=> (state == TXS_FETCH)); // R5

endmodule

// File: rtl/txd_beat_ctr.sv
module txd_beat_ctr #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             beat,
    output logic             last_beat
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)       remain <= '0;
        else if (load) remain <= load_len;
        else if (beat) remain <= remain - ONE;
    end

    assign last_beat = beat && (remain == ONE);

    AST_BEAT_HAS_BUDGET: assert property (@(posedge clk) disable iff (rst)
        beat |-> (remain != '0)); // R6

endmodule

// File: rtl/txd_evt.sv
module txd_evt
    import txd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  txs_e              state,
    input  txs_e              nxt,
    input  logic              beat,
    input  logic [DATA_W-1:0] rd_data,
    output txd_evt_t          evt,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata
);

    txd_evt_t evt_d;

    always_comb begin
        evt_d.done_int = (state == TXS_CLOSE) && (nxt == TXS_FETCH);
        evt_d.unavail  = (state == TXS_FETCH) && (nxt == TXS_SUSP);
        evt_d.stopped  = is_active(state) && (nxt == TXS_STOP);
        evt_d.kick     = (state != TXS_WAIT) && (nxt == TXS_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt        <= '0;
            fifo_push  <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            evt       <= evt_d;
            fifo_push <= beat;
            if (beat) fifo_wdata <= rd_data;
        end
    end

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt)); // R9

    AST_UNAVAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        evt.unavail |=> !evt.unavail); // R4

endmodule

// File: rtl/txdesc_seq.sv
module txdesc_seq
    import txd_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              poll_demand,
    output logic              desc_req,
    input  logic              desc_ack,
    input  logic              desc_own,
    input  logic [LEN_W-1:0]  desc_len,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              tx_kick,
    input  logic              tx_done,
    output logic              wb_req,
    input  logic              wb_ack,
    output logic [2:0]        state_code,
    output logic              ev_tx_int,
    output logic              ev_tx_unavail,
    output logic              ev_tx_stopped
);

    txs_e     state;
    txs_e     nxt;
    txd_evt_t evt;
    logic     beat;
    logic     last_beat;
    logic     load;
    logic     len_zero;

    assign len_zero = (desc_len == '0);
    assign load     = (state == TXS_FETCH) && desc_ack && desc_own && !cmd_stop;
    assign desc_req = (state == TXS_FETCH);
    assign rd_req   = (state == TXS_READ) && !fifo_full;
    assign wb_req   = (state == TXS_CLOSE);
    assign beat     = rd_req && rd_ack;

    txd_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .poll_demand (poll_demand),
        .desc_ack    (desc_ack),
        .desc_own    (desc_own),
        .len_zero    (len_zero),
        .last_beat   (last_beat),
        .tx_done     (tx_done),
        .wb_ack      (wb_ack),
        .state       (state),
        .nxt         (nxt)
    );

    txd_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_len  (desc_len),
        .beat      (beat),
        .last_beat (last_beat)
    );

    txd_evt #(.DATA_W(DATA_W)) u_evt (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .nxt        (nxt),
        .beat       (beat),
        .rd_data    (rd_data),
        .evt        (evt),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata)
    );

    assign state_code    = state;
    assign tx_kick       = evt.kick;
    assign ev_tx_int     = evt.done_int;
    assign ev_tx_unavail = evt.unavail;
    assign ev_tx_stopped = evt.stopped;

    AST_RD_ONLY_IN_READ: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (state_code == 3'b011 && !fifo_full)); // R6

    AST_CLOSE_RAISES_INT: assert property (@(posedge clk) disable iff (rst)
        (wb_req && wb_ack && !cmd_stop) |=> (ev_tx_int && state_code == 3'b001)); // R8

    AST_DONE_TO_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'b010 && tx_done && !cmd_stop) |=> (state_code == 3'b111)); // R7

endmodule

// File: tb/txdesc_seq_test.sv
module txdesc_seq_test;

    localparam int LEN_W  = 8;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst;
    logic cmd_start, cmd_stop, poll_demand;
    logic desc_req, desc_ack, desc_own;
    logic [LEN_W-1:0] desc_len;
    logic rd_req, rd_ack, fifo_full, fifo_push;
    logic [DATA_W-1:0] rd_data, fifo_wdata;
    logic tx_kick, tx_done, wb_req, wb_ack;
    logic [2:0] state_code;
    logic ev_tx_int, ev_tx_unavail, ev_tx_stopped;

    int n_checks = 0;
    int n_fail   = 0;
    int n_bad_code = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    txdesc_seq #(.LEN_W(LEN_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .poll_demand(poll_demand), .desc_req(desc_req), .desc_ack(desc_ack),
        .desc_own(desc_own), .desc_len(desc_len), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_data(rd_data), .fifo_full(fifo_full), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .tx_kick(tx_kick), .tx_done(tx_done),
        .wb_req(wb_req), .wb_ack(wb_ack), .state_code(state_code),
        .ev_tx_int(ev_tx_int), .ev_tx_unavail(ev_tx_unavail),
        .ev_tx_stopped(ev_tx_stopped)
    );

    // R10: watch for reserved codes on every cycle after reset
    always @(negedge clk)
        if (!rst && (state_code == 3'b100 || state_code == 3'b101)) n_bad_code++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cmd_start = 0; cmd_stop = 0; poll_demand = 0;
        desc_ack = 0; desc_own = 0; desc_len = '0;
        rd_ack = 0; rd_data = '0; fifo_full = 0;
        tx_done = 0; wb_ack = 0;
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs();
        step(); step();
        rst = 0;
        check("R1 state", state_code, 3'b000);
        check("R1 reqs", {desc_req, rd_req, wb_req}, 3'b000);
        check("R1 pulses", {fifo_push, tx_kick, ev_tx_int, ev_tx_unavail, ev_tx_stopped}, 5'b0);
    endtask

    task automatic t_idle_ignores();
        poll_demand = 1; desc_ack = 1; desc_own = 1; wb_ack = 1; tx_done = 1; rd_ack = 1;
        step(); idle_inputs();
        check("R5 poll in stopped", state_code, 3'b000);
        cmd_stop = 1;
        step(); idle_inputs();
        check("R9 stop in stopped no pulse", {state_code, ev_tx_stopped}, 4'b0000);
    endtask

    task automatic t_start();
        cmd_start = 1;
        step(); idle_inputs();
        check("R2 start", state_code, 3'b001);
        check("R3 desc_req", desc_req, 1);
    endtask

    task automatic t_frame();
        desc_ack = 1; desc_own = 1; desc_len = 8'd3; cmd_start = 1;
        step(); idle_inputs();
        check("R3 owned to read", state_code, 3'b011);
        check("R2 start ignored while running", ev_tx_stopped, 0);
        fifo_full = 1; rd_ack = 1; rd_data = 32'hDEAD;
        #1;
        check("R6 rd_req low when full", rd_req, 0);
        step();
        check("R6 ack ignored when full", {state_code, fifo_push}, {3'b011, 1'b0});
        fifo_full = 0;
        for (int i = 0; i < 3; i++) begin
            rd_ack = 1; rd_data = 32'hA0 + i;
            #1;
            check("R6 rd_req high", rd_req, 1);
            step();
            check("R6 push", fifo_push, 1);
            check("R6 push data", fifo_wdata, 32'hA0 + i);
            check("R6 state after beat", state_code, (i == 2) ? 3'b010 : 3'b011);
        end
        rd_ack = 0;
        check("R7 kick on entry", tx_kick, 1);
        step();
        check("R7 kick one cycle", {tx_kick, fifo_push}, 2'b00);
        tx_done = 1;
        step(); idle_inputs();
        check("R7 done to close", state_code, 3'b111);
        check("R8 wb_req", wb_req, 1);
        wb_ack = 1;
        step(); idle_inputs();
        check("R8 close to fetch", state_code, 3'b001);
        check("R8 int pulse", ev_tx_int, 1);
        step();
        check("R8 int one cycle", ev_tx_int, 0);
    endtask

    task automatic t_zero_len();
        desc_ack = 1; desc_own = 1; desc_len = 8'd0;
        step(); idle_inputs();
        check("R3 zero length to wait", state_code, 3'b010);
        check("R7 kick zero length", {tx_kick, fifo_push}, 2'b10);
        tx_done = 1; step(); idle_inputs();
        wb_ack = 1; step(); idle_inputs();
        check("R8 back to fetch", state_code, 3'b001);
    endtask

    task automatic t_unavail();
        poll_demand = 1;
        step(); idle_inputs();
        check("R5 poll in fetch", state_code, 3'b001);
        desc_ack = 1; desc_own = 0; desc_len = 8'd4;
        step(); idle_inputs();
        check("R4 suspend", state_code, 3'b110);
        check("R4 unavail pulse", ev_tx_unavail, 1);
        desc_ack = 1;
        step(); idle_inputs();
        check("R4 pulse one cycle", {state_code, ev_tx_unavail}, {3'b110, 1'b0});
        poll_demand = 1;
        step(); idle_inputs();
        check("R5 poll resumes", state_code, 3'b001);
    endtask

    task automatic t_stop_collide();
        desc_ack = 1; desc_own = 1; desc_len = 8'd0;
        step(); idle_inputs();
        tx_done = 1; step(); idle_inputs();
        check("R7 in close", state_code, 3'b111);
        cmd_stop = 1; wb_ack = 1;
        step(); idle_inputs();
        check("R9 stop beats writeback", state_code, 3'b000);
        check("R9 stopped pulse", ev_tx_stopped, 1);
        check("R9 no int on collision", ev_tx_int, 0);
    endtask

    task automatic t_stop_susp();
        cmd_start = 1; step(); idle_inputs();
        desc_ack = 1; desc_own = 0; step(); idle_inputs();
        cmd_stop = 1; poll_demand = 1;
        step(); idle_inputs();
        check("R9 stop from suspend", {state_code, ev_tx_stopped, ev_tx_unavail}, {3'b000, 1'b1, 1'b0});
    endtask

    task automatic t_stop_read();
        cmd_start = 1; step(); idle_inputs();
        desc_ack = 1; desc_own = 1; desc_len = 8'd2; step(); idle_inputs();
        check("R3 read again", state_code, 3'b011);
        cmd_stop = 1; rd_ack = 1;
        step(); idle_inputs();
        check("R9 stop from read", {state_code, ev_tx_stopped, tx_kick}, {3'b000, 1'b1, 1'b0});
    endtask

    initial begin
        t_reset();
        t_idle_ignores();
        t_start();
        t_frame();
        t_zero_len();
        t_unavail();
        t_stop_collide();
        t_stop_susp();
        t_stop_read();
        check("R10 no reserved code", n_bad_code, 0);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule